// File: doc/BRIEF.md
# I2C Bit-Level Bus Engine

This block is the line-level half of an I2C master. A controller above it issues one bus command at a time: a start condition, a repeated start, a stop condition, a byte write that checks the acknowledge slot, or a byte read that ends by clocking out an acknowledge bit of the controller's choosing. The engine turns each command into a fixed series of line phases. In each phase it holds SCL and SDA at set levels, drives them through active-high pull-down enables, and samples SDA where the protocol calls for it.

Each phase lasts a whole number of system-clock cycles, picked by a two-bit speed class when the command is accepted. While a command runs, `busy` is high. A one-cycle `done` pulse closes the command. The received byte and the acknowledge flag can then be read and stay put until the next command is accepted. Clock stretching, arbitration and target mode are not part of this block.

Top module: `i2c_bit_engine`

## Requirements
- R1: During and after reset, before any command, `scl_pd` and `sda_pd` are 0 (both lines released), `busy` and `done` are 0, and `rx_byte` and `ack_ok` are 0.
- R2: Every line phase lasts SLOW_TICKS (10) cycles for speed class 2'b00, MID_TICKS (3) cycles for 2'b01, and FAST_TICKS (1) cycle for 2'b10 or 2'b11.
- R3: Opcode 3'd0 (start) drives three phases as (SCL,SDA) levels: (1,1), then (1,0), then (0,0).
- R4: Opcode 3'd1 (repeated start) drives four phases: (0,1), (1,1), (1,0), (0,0).
- R5: Opcode 3'd2 (stop) drives three phases: (0,0), (1,0), (1,1).
- R6: Opcode 3'd3 (write) sends `tx_byte` MSB first, each bit as three phases (0,b), (1,b), (0,b). It then releases SDA for three phases (0,1), (1,1), (0,1) and samples SDA at the end of that high phase. `ack_ok` becomes 1 if SDA was low and 0 if it was high. Within the byte, SDA changes only while SCL is low.
- R7: Opcode 3'd4 (read) releases SDA for one low phase and then for eight high/low phase pairs. At the end of each high phase it shifts the sampled SDA into bit 0 of `rx_byte`, so the first bit ends up as the MSB. It then drives `cmd_ack_bit` for three phases (0,a), (1,a), (0,a).
- R8: A command is accepted on a clock edge where `cmd_valid` is high, `busy` is low and the opcode is 0 to 4. `busy` is high for exactly N×P cycles, where N is the command's phase count and P the phase length. `done` is high for one cycle, the one in which `busy` first reads low.
- R9: `cmd_valid` is ignored while `busy` is high, and opcodes 3'd5 to 3'd7 are ignored: no `busy`, no `done`, no change of the lines.
- R10: Acceptance clears `rx_byte` and `ack_ok` to 0. A write sets only `ack_ok` and a read sets only `rx_byte`. Both hold from `done` until the next acceptance.
- R11: Between commands both lines keep the levels of the last phase of the previous command.
- R12: The phase length is fixed at acceptance. Changing `speed_cls` while `busy` is high does not alter the running command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| speed_cls | input | 2 | Speed class: 00 slow, 01 mid, 1x fast |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | 0 start, 1 repeated start, 2 stop, 3 write, 4 read |
| cmd_ack_bit | input | 1 | SDA level clocked out after a read byte |
| tx_byte | input | 8 | Byte to write |
| sda_in | input | 1 | Sampled SDA line level |
| scl_pd | output | 1 | SCL pull-down enable |
| sda_pd | output | 1 | SDA pull-down enable |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_byte | output | 8 | Byte read from the bus |
| ack_ok | output | 1 | Target acknowledged the written byte |

## Verification
The bench builds the engine with its default phase lengths of 10, 3 and 1 cycles and switches the speed class between commands, so each line phase is seen with every length. With the one-cycle class, a sample that lands one cycle early or late reads the neighbouring phase's data. The ten-cycle class shows whether each level is held through the whole phase. A speed change and a stray command injected in the middle of a write bring R9 and R12 within reach, and a modelled target drives ack and nack as well as read data of varied bit patterns.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

  localparam int STEP_W = 5;

  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_RSTART = 3'd1,
    OP_STOP   = 3'd2,
    OP_WRITE  = 3'd3,
    OP_READ   = 3'd4
  } op_e;

  typedef struct packed {
    logic scl;
    logic sda;
    logic smp;
  } lines_t;

  function automatic logic op_known(logic [2:0] code);
    return code <= 3'd4;
  endfunction

  function automatic logic [STEP_W-1:0] step_total(op_e op);
    case (op)
      OP_RSTART: return 5'd4;
      OP_WRITE:  return 5'd27;
      OP_READ:   return 5'd20;
      default:   return 5'd3;
    endcase
  endfunction

  function automatic int unsigned phase_len(logic [1:0] cls, int unsigned slow_t,
                                            int unsigned mid_t, int unsigned fast_t);
    if (cls == 2'b00) return slow_t;
    if (cls == 2'b01) return mid_t;
    return fast_t;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Line levels of phase k of a command (1 = released/high).
  function automatic lines_t step_lines(op_e op, logic [STEP_W-1:0] k,
                                        logic [7:0] tx, logic ack_bit);
    lines_t r;
    logic [STEP_W-1:0] j;
    logic [STEP_W-1:0] rem;
    r   = '{scl: 1'b1, sda: 1'b1, smp: 1'b0};
    j   = k / 5'd3;
    rem = k % 5'd3;
    case (op)
      OP_START: begin
        r.scl = (k != 5'd2);
        r.sda = (k == 5'd0);
      end
      OP_RSTART: begin
        r.scl = (k == 5'd1) || (k == 5'd2);
        r.sda = (k < 5'd2);
      end
      OP_STOP: begin
        r.scl = (k != 5'd0);
        r.sda = (k == 5'd2);
      end
      OP_WRITE: begin
        if (k < 5'd24) begin
          r.scl = (rem == 5'd1);
          r.sda = tx[3'd7 - j[2:0]];
        end else begin
          r.scl = (k == 5'd25);
          r.smp = (k == 5'd25);
        end
      end
      OP_READ: begin
        if (k == 5'd0) begin
          r.scl = 1'b0;
        end else if (k < 5'd17) begin
          j     = k - 5'd1;
          r.scl = ~j[0];
          r.smp = ~j[0];
        end else begin
          r.scl = (k == 5'd18);
          r.sda = ack_bit;
        end
      end
      default: ;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [CNT_W-1:0] len,
  output logic [CNT_W-1:0] count,
  output logic             phase_end
);
  assign phase_end = run && (count == len - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  count <= '0;
    else if (clear || phase_end) count <= '0;
    else if (run)                count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/i2c_step_decode.sv
module i2c_step_decode
  import i2c_eng_pkg::*;
(
  input  op_e               op,
  input  logic [STEP_W-1:0] step,
  input  logic [7:0]        tx,
  input  logic              ack_bit,
  output lines_t            lines
);
  assign lines = step_lines(op, step, tx, ack_bit);
endmodule

// File: rtl/i2c_rx_capture.sv
module i2c_rx_capture (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       shift_en,
  input  logic       ack_en,
  input  logic       sda_in,
  output logic [7:0] rx_byte,
  output logic       ack_ok
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte <= '0;
      ack_ok  <= 1'b0;
    end else if (clear) begin
      rx_byte <= '0;
      ack_ok  <= 1'b0;
    end else begin
      if (shift_en) rx_byte <= {rx_byte[6:0], sda_in};
      if (ack_en)   ack_ok  <= ~sda_in;
    end
  end
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_eng_pkg::*;
#(
  parameter int unsigned SLOW_TICKS = 10,
  parameter int unsigned MID_TICKS  = 3,
  parameter int unsigned FAST_TICKS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] speed_cls,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_op,
  input  logic       cmd_ack_bit,
  input  logic [7:0] tx_byte,
  input  logic       sda_in,
  output logic       scl_pd,
  output logic       sda_pd,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       ack_ok
);
  localparam int unsigned MAX_TICKS = max3(SLOW_TICKS, MID_TICKS, FAST_TICKS);
  localparam int CNT_W = (MAX_TICKS < 2) ? 1 : $clog2(MAX_TICKS + 1);

  logic              busy_q, done_q;
  op_e               op_q;
  logic [STEP_W-1:0] step_q;
  logic [7:0]        tx_q;
  logic              ackbit_q;
  logic [CNT_W-1:0]  len_q;
  logic              scl_lvl_q, sda_lvl_q, smp_q;

  // Named internal events used by the checker.
  logic              cmd_take;
  logic              phase_end;
  logic              last_step;
  logic              mid_byte;
  logic [CNT_W-1:0]  tick_cnt;

  op_e               nxt_op;
  logic [STEP_W-1:0] nxt_step;
  logic [7:0]        nxt_tx;
  logic              nxt_ack;
  lines_t            nxt_lines;

  assign cmd_take  = cmd_valid && !busy_q && op_known(cmd_op);
  assign last_step = (step_q == step_total(op_q) - 5'd1);
  assign mid_byte  = busy_q && (op_q == OP_WRITE || op_q == OP_READ) && (step_q != '0);

  assign nxt_op   = cmd_take ? op_e'(cmd_op) : op_q;
  assign nxt_step = cmd_take ? '0 : step_q + 5'd1;
  assign nxt_tx   = cmd_take ? tx_byte : tx_q;
  assign nxt_ack  = cmd_take ? cmd_ack_bit : ackbit_q;

  i2c_step_decode u_decode (
    .op      (nxt_op),
    .step    (nxt_step),
    .tx      (nxt_tx),
    .ack_bit (nxt_ack),
    .lines   (nxt_lines)
  );

  i2c_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (cmd_take),
    .run       (busy_q),
    .len       (len_q),
    .count     (tick_cnt),
    .phase_end (phase_end)
  );

  i2c_rx_capture u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cmd_take),
    .shift_en (phase_end && smp_q && op_q == OP_READ),
    .ack_en   (phase_end && smp_q && op_q == OP_WRITE),
    .sda_in   (sda_in),
    .rx_byte  (rx_byte),
    .ack_ok   (ack_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      op_q      <= OP_START;
      step_q    <= '0;
      tx_q      <= '0;
      ackbit_q  <= 1'b0;
      len_q     <= CNT_W'(FAST_TICKS);
      scl_lvl_q <= 1'b1;
      sda_lvl_q <= 1'b1;
      smp_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cmd_take) begin
        busy_q    <= 1'b1;
        op_q      <= nxt_op;
        step_q    <= '0;
        tx_q      <= tx_byte;
        ackbit_q  <= cmd_ack_bit;
        len_q     <= CNT_W'(phase_len(speed_cls, SLOW_TICKS, MID_TICKS, FAST_TICKS));
        scl_lvl_q <= nxt_lines.scl;
        sda_lvl_q <= nxt_lines.sda;
        smp_q     <= nxt_lines.smp;
      end else if (phase_end) begin
        if (last_step) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          smp_q  <= 1'b0;
        end else begin
          step_q    <= nxt_step;
          scl_lvl_q <= nxt_lines.scl;
          sda_lvl_q <= nxt_lines.sda;
          smp_q     <= nxt_lines.smp;
        end
      end
    end
  end

  assign scl_pd = ~scl_lvl_q;
  assign sda_pd = ~sda_lvl_q;
  assign busy   = busy_q;
  assign done   = done_q;
endmodule

// File: rtl/i2c_bit_engine_chk.sv
module i2c_bit_engine_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             cmd_take,
  input logic             mid_byte,
  input logic             scl_pd,
  input logic             sda_pd,
  input logic [7:0]       rx_byte,
  input logic             ack_ok,
  input logic [CNT_W-1:0] tick,
  input logic [CNT_W-1:0] len
);
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_ends_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_take_sets_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_take |=> busy && !done);

  p_results_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_take) |=> ($stable(rx_byte) && $stable(ack_ok)));

  p_lines_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_take) |=> ($stable(scl_pd) && $stable(sda_pd)));

  p_sda_moves_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_byte && !$stable(sda_pd)) |-> (scl_pd && $past(scl_pd)));

  p_tick_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tick < len));
endmodule

bind i2c_bit_engine i2c_bit_engine_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .cmd_take (cmd_take),
  .mid_byte (mid_byte),
  .scl_pd   (scl_pd),
  .sda_pd   (sda_pd),
  .rx_byte  (rx_byte),
  .ack_ok   (ack_ok),
  .tick     (tick_cnt),
  .len      (len_q)
);

// File: tb/test_i2c_bit_engine.sv
module test_i2c_bit_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] speed_cls = 2'b00;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic       cmd_ack_bit = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic       slave_pd = 1'b0;
  logic       sda_in;
  logic       scl_pd, sda_pd, busy, done, ack_ok;
  logic [7:0] rx_byte;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [2:0] q[$];   // per cycle: {scl level, sda level, target pull-down}

  always #10 clk = ~clk;
  assign sda_in = ~(sda_pd | slave_pd);

  i2c_bit_engine i_i2c_bit_engine (
    .clk(clk), .rst_n(rst_n), .speed_cls(speed_cls), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_ack_bit(cmd_ack_bit), .tx_byte(tx_byte), .sda_in(sda_in),
    .scl_pd(scl_pd), .sda_pd(sda_pd), .busy(busy), .done(done),
    .rx_byte(rx_byte), .ack_ok(ack_ok)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ticks_for(logic [1:0] s);
    case (s)
      2'b00:   return 10;
      2'b01:   return 3;
      default: return 1;
    endcase
  endfunction

  task automatic ph(input logic c, input logic d, input logic t, input int p);
    for (int n = 0; n < p; n++) q.push_back({c, d, t});
  endtask

  // Reference model: the command expanded to its per-cycle line levels.
  task automatic build(input logic [2:0] op, input logic [7:0] tx, input logic ab,
                       input logic [7:0] sb, input logic sack, input int p);
    q.delete();
    case (op)
      3'd0: begin ph(1,1,0,p); ph(1,0,0,p); ph(0,0,0,p); end
      3'd1: begin ph(0,1,0,p); ph(1,1,0,p); ph(1,0,0,p); ph(0,0,0,p); end
      3'd2: begin ph(0,0,0,p); ph(1,0,0,p); ph(1,1,0,p); end
      3'd3: begin
        for (int b = 7; b >= 0; b--) begin
          ph(0, tx[b], 0, p); ph(1, tx[b], 0, p); ph(0, tx[b], 0, p);
        end
        ph(0,1,sack,p); ph(1,1,sack,p); ph(0,1,sack,p);
      end
      default: begin
        ph(0, 1, ~sb[7], p);
        for (int b = 7; b >= 0; b--) begin
          ph(1, 1, ~sb[b], p);
          ph(0, 1, (b > 0) ? ~sb[b-1] : 1'b0, p);
        end
        ph(0,ab,0,p); ph(1,ab,0,p); ph(0,ab,0,p);
      end
    endcase
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic [7:0] tx, input logic ab,
                         input logic [7:0] sb, input logic sack, input logic [1:0] spd,
                         input bit poke, input string tag);
    logic [2:0] e;
    logic [7:0] exp_rx;
    logic       exp_ack;
    int         n;
    build(op, tx, ab, sb, sack, ticks_for(spd));
    n       = q.size();
    exp_rx  = (op == 3'd4) ? sb : 8'h00;
    exp_ack = (op == 3'd3) ? sack : 1'b0;
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; tx_byte = tx; cmd_ack_bit = ab; speed_cls = spd;
    @(negedge clk);
    cmd_valid = 0;
    for (int i = 0; i < n; i++) begin
      e = q[i];
      slave_pd = e[0];
      chk(scl_pd == ~e[2], {tag, " R2 scl"}, scl_pd, ~e[2]);
      chk(sda_pd == ~e[1], {tag, " R2 sda"}, sda_pd, ~e[1]);
      chk(busy && !done, "R8 busy", {busy, done}, 2'b10);
      if (poke && i == 2) begin   // R9 R12: stray command and speed change
        cmd_valid = 1; cmd_op = 3'd2; speed_cls = ~spd;
      end
      if (poke && i == 3) begin
        cmd_valid = 0; speed_cls = spd;
      end
      @(negedge clk);
    end
    slave_pd = 0;
    e = q[n-1];
    chk(done && !busy, "R8 done", {busy, done}, 2'b01);
    chk(rx_byte == exp_rx, {tag, " R10 rx"}, rx_byte, exp_rx);
    chk(ack_ok == exp_ack, {tag, " R10 ack"}, ack_ok, exp_ack);
    chk({scl_pd, sda_pd} == ~e[2:1], "R11 hold", {scl_pd, sda_pd}, ~e[2:1]);
    @(negedge clk);
    chk(!done && !busy, "R8 single pulse", {busy, done}, 2'b00);
    chk(rx_byte == exp_rx && ack_ok == exp_ack, "R10 stable", {rx_byte, ack_ok},
        {exp_rx, exp_ack});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({scl_pd, sda_pd, busy, done} == 4'b0, "R1 in reset", {scl_pd, sda_pd, busy, done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk({scl_pd, sda_pd, busy, done} == 4'b0, "R1 after reset", {scl_pd, sda_pd, busy, done}, 0);
    chk(rx_byte == 0 && ack_ok == 0, "R1 results", {rx_byte, ack_ok}, 0);

    run_cmd(3'd0, 8'h00, 0, 8'h00, 0, 2'b00, 0, "R3");
    repeat (4) begin
      @(negedge clk);
      chk(scl_pd && sda_pd, "R11 idle after start", {scl_pd, sda_pd}, 2'b11);
    end
    run_cmd(3'd3, 8'hA5, 0, 8'h00, 1, 2'b01, 0, "R6 ack");
    run_cmd(3'd3, 8'h3C, 0, 8'h00, 0, 2'b10, 1, "R6 nack R9 R12");
    run_cmd(3'd1, 8'h00, 0, 8'h00, 0, 2'b01, 0, "R4");
    run_cmd(3'd4, 8'h00, 0, 8'hC3, 0, 2'b00, 0, "R7 ack0");
    run_cmd(3'd4, 8'h00, 1, 8'h5A, 0, 2'b10, 0, "R7 ack1");
    run_cmd(3'd3, 8'h81, 0, 8'h00, 1, 2'b11, 0, "R6 fast");

    // R9: unknown opcodes are ignored while idle
    for (int c = 5; c < 8; c++) begin
      @(negedge clk);
      cmd_valid = 1; cmd_op = 3'(c);
      @(negedge clk);
      cmd_valid = 0;
      repeat (3) begin
        chk(!busy && !done, "R9 bad opcode", {busy, done}, 0);
        chk(scl_pd && !sda_pd, "R9 lines kept", {scl_pd, sda_pd}, 2'b10);
        chk(ack_ok == 1'b1, "R10 ack kept", ack_ok, 1);
        @(negedge clk);
      end
    end

    run_cmd(3'd2, 8'h00, 0, 8'h00, 0, 2'b11, 0, "R5");
    repeat (3) begin
      @(negedge clk);
      chk(!scl_pd && !sda_pd, "R11 idle after stop", {scl_pd, sda_pd}, 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule